// File: doc/BRIEF.md
# Serial Flash Second Status Byte Write Handler

This block sits on the command path of a serial flash and handles the write of the second status byte. It receives serial commands in SPI mode 0, most significant bit first. The chip-select (active low), serial clock and serial data inputs arrive already synchronised to the core clock. The block samples serial data on each rising edge of the serial clock while chip select is low. It holds the opcode byte and the first data byte. All register changes are decided at the cycle in which chip select returns high.

The block holds four state bits. The first is a write-enable latch. The second is a reset-enable bit. The third is a lockdown-enable bit. The fourth is a sticky freeze flag that protects only the lockdown-enable bit. Three opcodes are decoded. One arms the latch. One writes the status byte. One sets the freeze flag. The serial output is never driven.

Top module: `sflash_sr2_writer`

## Requirements
- R1: The status-byte write uses opcode 0x31. One data byte follows it. Both bytes are sampled MSB first on rising serial-clock edges while `csN` is low.
- R2: Data bit 4 is the new `resetEn` value and data bit 3 is the new `lockEn` value. Data bits 7..5 and 2..0 have no effect.
- R3: A 0x31 command that starts while `writeEn` is 0 changes no state.
- R4: `resetEn` and `lockEn` do not change while `csN` is low. They change only in the cycle after `csN` rises.
- R5: Any bytes after the first data byte are discarded.
- R6: A 0x31 frame is aborted if it ends with fewer than 16 bits, or with a bit count that is not a multiple of 8. On abort, `resetEn` and `lockEn` keep their values.
- R7: Any 0x31 or 0x34 frame that started with `writeEn` set clears `writeEn` when it ends, whether it completed or was aborted.
- R8: Once `lockFrozen` is set, `lockEn` can no longer change, but `resetEn` can still be written. `lockFrozen` stays set until reset.
- R9: Opcode 0x06 sets `writeEn` when `csN` rises, provided the frame holds at least 8 bits and its bit count is a multiple of 8.
- R10: Opcode 0x34 sets `lockFrozen` only if `writeEn` is set and the frame ends on a byte boundary.
- R11: An unrecognised opcode, or a frame shorter than 8 bits, has no effect.
- R12: A serial-clock rising edge that arrives in the same cycle as `csN` rising is not counted as a bit.
- R13: Synchronous `rst` clears `writeEn`, `resetEn`, `lockEn` and `lockFrozen`. `soOe` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low, synchronised |
| sck | input | 1 | Serial clock, synchronised |
| si | input | 1 | Serial data in |
| soOe | output | 1 | Serial output enable, held 0 |
| writeEn | output | 1 | Write-enable latch |
| resetEn | output | 1 | Reset-enable status bit |
| lockEn | output | 1 | Lockdown-enable status bit |
| lockFrozen | output | 1 | Sticky lockdown freeze flag |

## Verification
Two events can fall in the same core-clock cycle: a serial-clock rising edge and the end of a frame. The bench provokes this by raising `sck` and `csN` at the same time on the sixteenth bit of an armed 0x31 write. That edge must be dropped, which leaves 15 bits. The frame must then count as an abort: `writeEn` clears and both status bits stay unchanged. Random frames of mixed length and opcode are checked against a bench model. Before each `csN` rise, the bench also confirms that no status bit moved mid-frame.

// File: rtl/sr2w_pkg.sv
package sr2w_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] OP_WREN   = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRSR2  = 8'h31;
  localparam logic [BYTE_W-1:0] OP_FREEZE = 8'h34;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic ldRste;
    logic ldSle;
    logic setFreeze;
  } strobe_t;
endpackage

// File: rtl/sr2w_datapath.sv
module sr2w_datapath
  import sr2w_pkg::*;
#(
  parameter int RSTE_POS = 4,
  parameter int SLE_POS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  strobe_t           strb,
  output logic              endFrame,
  output logic              aligned,
  output logic [1:0]        byteCnt,
  output logic [BYTE_W-1:0] opcode,
  output logic [BYTE_W-1:0] dataByte,
  output logic              writeEn,
  output logic              resetEn,
  output logic              lockEn,
  output logic              lockFrozen
);
  logic                 sckQ;
  logic                 csQ;
  logic                 sckRise;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [BYTE_W-1:0]    shiftReg;
  logic [BYTE_W-1:0]    nextByte;

  // edges seen while chip select is high are dropped
  assign sckRise  = sck & ~sckQ & ~csN;
  assign endFrame = csN & ~csQ;
  assign aligned  = (bitIdx == '0);
  assign nextByte = {shiftReg[BYTE_W-2:0], si};

  always_ff @(posedge clk) begin
    if (rst) begin
      sckQ     <= 1'b0;
      csQ      <= 1'b1;
      bitIdx   <= '0;
      byteCnt  <= '0;
      shiftReg <= '0;
      opcode   <= '0;
      dataByte <= '0;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
      if (csN) begin
        bitIdx  <= '0;
        byteCnt <= '0;
      end else if (sckRise) begin
        shiftReg <= nextByte;
        bitIdx   <= bitIdx + 1'b1;
        if (bitIdx == BIT_IDX_W'(BYTE_W - 1)) begin
          if (byteCnt == 2'd0) opcode <= nextByte;
          if (byteCnt == 2'd1) dataByte <= nextByte;
          if (byteCnt != 2'd2) byteCnt <= byteCnt + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      writeEn    <= 1'b0;
      resetEn    <= 1'b0;
      lockEn     <= 1'b0;
      lockFrozen <= 1'b0;
    end else begin
      if (strb.setWel)         writeEn <= 1'b1;
      else if (strb.clrWel)    writeEn <= 1'b0;
      if (strb.ldRste)         resetEn <= dataByte[RSTE_POS];
      if (strb.ldSle)          lockEn  <= dataByte[SLE_POS];
      if (strb.setFreeze)      lockFrozen <= 1'b1;
    end
  end

  AST_MIDFRAME_STABLE: assert property (@(posedge clk) disable iff (rst)
    !endFrame |=> $stable(resetEn) && $stable(lockEn)); // R4
  AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (rst)
    lockFrozen |=> lockFrozen); // R8
  AST_FROZEN_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    lockFrozen |=> $stable(lockEn)); // R8
  AST_FREEZE_CONSUMES_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(lockFrozen) |-> $past(writeEn) && !writeEn); // R10
endmodule

// File: rtl/sr2w_ctrl.sv
module sr2w_ctrl
  import sr2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              endFrame,
  input  logic              aligned,
  input  logic [1:0]        byteCnt,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              writeEn,
  input  logic              lockFrozen,
  output strobe_t           strb
);
  logic opValid;
  logic isWren;
  logic isWrite;
  logic isFreeze;

  assign opValid  = endFrame && (byteCnt != 2'd0);
  assign isWren   = (opcode == OP_WREN);
  assign isWrite  = (opcode == OP_WRSR2);
  assign isFreeze = (opcode == OP_FREEZE);

  always_comb begin
    strb = '0;
    if (opValid) begin
      if (isWren && aligned) begin
        strb.setWel = 1'b1;
      end
      if (isFreeze && writeEn) begin
        strb.clrWel    = 1'b1;
        strb.setFreeze = aligned;
      end
      if (isWrite && writeEn) begin
        strb.clrWel = 1'b1;
        if (aligned && byteCnt == 2'd2) begin
          strb.ldRste = 1'b1;
          strb.ldSle  = !lockFrozen;
        end
      end
    end
  end

  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (opValid && isWrite && writeEn) |=> !writeEn); // R7
  AST_LOAD_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    strb.ldRste |-> writeEn && endFrame); // R3
  AST_SHORT_FRAME_IDLE: assert property (@(posedge clk) disable iff (rst)
    (endFrame && byteCnt == 2'd0) |-> strb == '0); // R11
endmodule

// File: rtl/sflash_sr2_writer.sv
module sflash_sr2_writer
  import sr2w_pkg::*;
#(
  parameter int RSTE_POS = 4,
  parameter int SLE_POS  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic soOe,
  output logic writeEn,
  output logic resetEn,
  output logic lockEn,
  output logic lockFrozen
);
  strobe_t           strb;
  logic              endFrame;
  logic              aligned;
  logic [1:0]        byteCnt;
  logic [BYTE_W-1:0] opcode;
  logic [BYTE_W-1:0] dataByte;

  assign soOe = 1'b0;

  sr2w_datapath #(.RSTE_POS(RSTE_POS), .SLE_POS(SLE_POS)) u_dp (
    .clk(clk), .rst(rst), .csN(csN), .sck(sck), .si(si), .strb(strb),
    .endFrame(endFrame), .aligned(aligned), .byteCnt(byteCnt),
    .opcode(opcode), .dataByte(dataByte), .writeEn(writeEn),
    .resetEn(resetEn), .lockEn(lockEn), .lockFrozen(lockFrozen)
  );

  sr2w_ctrl u_ctrl (
    .clk(clk), .rst(rst), .endFrame(endFrame), .aligned(aligned),
    .byteCnt(byteCnt), .opcode(opcode), .writeEn(writeEn),
    .lockFrozen(lockFrozen), .strb(strb)
  );
endmodule

// File: tb/sflash_sr2_writer_tb.sv
module sflash_sr2_writer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic si  = 1'b0;
  logic soOe, writeEn, resetEn, lockEn, lockFrozen;

  int checks = 0;
  int errors = 0;
  bit expWel, expRste, expSle, expFrz;

  always #2 clk = ~clk;

  sflash_sr2_writer u_dut (
    .clk(clk), .rst(rst), .csN(csN), .sck(sck), .si(si), .soOe(soOe),
    .writeEn(writeEn), .resetEn(resetEn), .lockEn(lockEn), .lockFrozen(lockFrozen)
  );

  function automatic logic [4:0] expVec();
    return {1'b0, expWel, expRste, expSle, expFrz};
  endfunction

  task automatic checkState(input string tag);
    logic [4:0] got;
    got = {soOe, writeEn, resetEn, lockEn, lockFrozen};
    checks++;
    if (got !== expVec()) begin
      errors++;
      $display("FAIL %s: {soOe,wel,rste,sle,frz} got %b expected %b", tag, got, expVec());
    end
  endtask

  // bench model of one frame with nbits effective bits
  task automatic model(input logic [7:0] op, input logic [7:0] dat, input int nbits);
    bit al;
    al = (nbits % 8) == 0;
    if (nbits < 8) return;
    if (op == 8'h06) begin
      if (al) expWel = 1'b1;
    end else if (op == 8'h34) begin
      if (expWel) begin
        if (al) expFrz = 1'b1;
        expWel = 1'b0;
      end
    end else if (op == 8'h31) begin
      if (expWel) begin
        if (al && nbits >= 16) begin
          expRste = dat[4];
          if (!expFrz) expSle = dat[3];
        end
        expWel = 1'b0;
      end
    end
  endtask

  task automatic frame(input logic [7:0] op, input logic [7:0] dat, input int nbits,
                       input bit clash, input string tag);
    csN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 8) ? op[7-i] : (i < 16) ? dat[15-i] : 1'($urandom_range(0, 1));
      repeat (2) @(negedge clk);
      if (clash && i == nbits - 1) begin
        checkState({tag, " R4 midframe"});
        sck = 1'b1;
        csN = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
      end else begin
        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
      end
    end
    if (!clash) begin
      repeat (2) @(negedge clk);
      checkState({tag, " R4 midframe"});
      csN = 1'b1;
    end
    repeat (3) @(negedge clk);
    model(op, dat, clash ? nbits - 1 : nbits);
    checkState(tag);
  endtask

  task automatic randomPhase(input int n);
    for (int k = 0; k < n; k++) begin
      int sel;
      int nb;
      logic [7:0] op;
      sel = $urandom_range(0, 19);
      op = (sel < 7) ? 8'h06 : (sel < 15) ? 8'h31 : (sel == 15) ? 8'h34 : 8'($urandom);
      nb = ($urandom_range(0, 9) < 7) ? 8 * $urandom_range(1, 4) : $urandom_range(1, 30);
      frame(op, 8'($urandom), nb, 1'b0, "random");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkState("R13 reset");

    frame(8'h31, 8'h18, 16, 1'b0, "R3 write without latch");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h31, 8'h10, 16, 1'b0, "R1 R2 write rste");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h31, 8'hE7, 16, 1'b0, "R2 ignored bits");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h31, 8'h08, 40, 1'b0, "R5 trailing bytes");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h31, 8'h10, 12, 1'b0, "R6 R7 short abort");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h31, 8'h10, 17, 1'b0, "R6 R7 unaligned abort");
    frame(8'h06, 8'h00, 5, 1'b0, "R9 R11 partial opcode");
    frame(8'h06, 8'h00, 11, 1'b0, "R9 unaligned arm");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'hA5, 8'h18, 16, 1'b0, "R11 unknown opcode");
    frame(8'h31, 8'h18, 16, 1'b1, "R12 clash abort");

    randomPhase(150);

    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h31, 8'h08, 16, 1'b0, "R2 set sle");
    frame(8'h34, 8'h00, 8, 1'b0, "R10 freeze without latch");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h34, 8'h00, 13, 1'b0, "R10 R7 unaligned freeze");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h34, 8'h00, 8, 1'b0, "R10 freeze");
    frame(8'h06, 8'h00, 8, 1'b0, "R9 arm");
    frame(8'h31, 8'h10, 16, 1'b0, "R8 rste writable frozen sle held");

    randomPhase(60);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expWel = 0; expRste = 0; expSle = 0; expFrz = 0;
    @(negedge clk);
    checkState("R13 reset clears");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule